// File: doc/BRIEF.md
# I2C Bus Clock Timing Generator

This block paces the clock line of an I2C master. A protocol sequencer hands it one command at a time: clock out one bit, create a START from a free bus, create a repeated START from a parked bus, or create a STOP. The generator holds SCL low or lets it go, and it tells the sequencer in which system clock cycle to move SDA, to sample SDA, and to make the START or STOP edge on SDA. Four counts in system clock cycles set the timing: the full SCL period, the SCL low time, the setup time before a repeated START or STOP edge, and the setup time of data before the rising SCL edge.

A period count of zero selects a built-in period equal to the system clock rate divided by the bus rate. Both rates are parameters, and the bus rate is held between 1 Hz and 400 kHz, with zero meaning 100 kHz. An automatic mode derives the other three counts from the period: the low time and the edge setup are half the period, and the data setup is one sixteenth of it. The high phase is counted only after SCL reads back high, so a target that holds the clock low lengthens the bit. The counts are captured when a command is accepted.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset SCL is released (`scl_drive_low`=0), `cmd_ready` is 1 and all strobes are 0.
- R2: The period in use is `cfg_period`, or SYS_HZ/BUS_HZ when `cfg_period` is 0. With `cfg_auto`=1 the low count and the edge setup count are period/2 and the data setup count is period/16, truncated. With `cfg_auto`=0 they come from `cfg_low`, `cfg_setup` and `cfg_dsetup`.
- R3: A bit, repeated START or STOP command accepted from the parked state drives SCL low for L cycles, where L is the low count (0 counts as 1). This low phase starts in the cycle after acceptance.
- R4: `sda_change` is high for exactly one cycle of the low phase, at index L-D (index 0 is the first low cycle). D is the data setup count clamped to the range 1..L.
- R5: After the low phase SCL is released. The high phase starts in the cycle after `scl_in` is first seen high. While `scl_in` stays low, no strobe fires and `cmd_done` stays 0.
- R6: A bit command (`cmd_op`=0) has a high phase of H cycles, where H is the period minus L, or 1 when the period is not larger than L. `sda_sample` fires in the first high cycle and `cmd_done` in the last. SCL is then held low and `cmd_ready` returns to 1.
- R7: START (`cmd_op`=1, from idle, with no low phase) and repeated START (`cmd_op`=2, from parked) fire `start_edge` at high index S, where S is the edge setup count. The high phase lasts max(H, S+1) cycles and `cmd_done` fires in its last cycle. The block then parks with SCL low.
- R8: STOP (`cmd_op`=3) fires `stop_edge` and `cmd_done` together at high index S. From the next cycle SCL stays released in the idle state.
- R9: `cmd_ready` is 1 only in idle and parked. A command presented while it is 0 is dropped.
- R10: In idle only START is acted on, and in parked START is dropped. A dropped command leaves the outputs unchanged.
- R11: The counts are captured in the accepting cycle. Changing them while a command runs does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto | input | 1 | Derive low, edge setup and data setup counts from the period |
| cfg_period | input | CW | Full SCL period in cycles, 0 selects the built-in period |
| cfg_low | input | CW | SCL low count |
| cfg_setup | input | CW | Setup count before a repeated START or STOP edge |
| cfg_dsetup | input | CW | Data setup count before the rising SCL edge |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 bit, 1 START, 2 repeated START, 3 STOP |
| cmd_ready | output | 1 | Block is idle or parked and can take a command |
| scl_in | input | 1 | Read back of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_change | output | 1 | Sequencer may change SDA now |
| sda_sample | output | 1 | Sequencer samples SDA now |
| start_edge | output | 1 | Sequencer pulls SDA low now (START or repeated START) |
| stop_edge | output | 1 | Sequencer releases SDA high now (STOP) |
| cmd_done | output | 1 | Last cycle of the current command |

## Verification
Two pairs of events can land on the same cycle. The START or STOP edge can fall on the final high cycle together with `cmd_done`, and the data change strobe can fall on the first low cycle. The bench provokes the first by giving an edge setup count larger than the high time, and the second by giving a data setup count larger than the low count or a zero low count. A cycle-accurate model predicts both strobes and the command end in the same cycle, and the model is compared with the outputs every cycle. A held SCL line is also applied while a bit ends its low phase, to check that the high phase waits for it.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;

    typedef enum logic [1:0] {
        OP_BIT     = 2'd0,
        OP_START   = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PARK = 3'd1,
        PH_LOW  = 3'd2,
        PH_WAIT = 3'd3,
        PH_HIGH = 3'd4
    } phase_e;

endpackage

// File: rtl/i2c_tim_cfg.sv
// Turns the programmed counts into the comparison points of one command.
module i2c_tim_cfg
    import i2c_tim_pkg::*;
#(
    parameter int                CW         = 16,
    parameter logic [CW-1:0]     DEF_PERIOD = 16'd1000
) (
    input  logic          cfg_auto,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_dsetup,
    input  op_e           op,
    output logic [CW-1:0] low_end,
    output logic [CW-1:0] chg_at,
    output logic [CW-1:0] edge_at,
    output logic [CW-1:0] hi_end
);
    logic [CW-1:0] period;
    logic [CW-1:0] low_raw;
    logic [CW-1:0] setup;
    logic [CW-1:0] dsu_raw;
    logic [CW-1:0] low_eff;
    logic [CW-1:0] dsu_eff;
    logic [CW-1:0] high_len;
    logic [CW-1:0] high_last;

    always_comb begin
        period  = (cfg_period == '0) ? DEF_PERIOD : cfg_period;
        low_raw = cfg_auto ? (period >> 1) : cfg_low;
        setup   = cfg_auto ? (period >> 1) : cfg_setup;
        dsu_raw = cfg_auto ? (period >> 4) : cfg_dsetup;

        low_eff = (low_raw == '0) ? CW'(1) : low_raw;

        if (dsu_raw == '0)
            dsu_eff = CW'(1);
        else if (dsu_raw > low_eff)
            dsu_eff = low_eff;
        else
            dsu_eff = dsu_raw;

        high_len  = (period > low_eff) ? (period - low_eff) : CW'(1);
        high_last = high_len - CW'(1);

        low_end = low_eff - CW'(1);
        chg_at  = low_eff - dsu_eff;
        edge_at = setup;

        unique case (op)
            OP_BIT:               hi_end = high_last;
            OP_START, OP_RESTART: hi_end = (setup > high_last) ? setup : high_last;
            OP_STOP:              hi_end = setup;
            default:              hi_end = high_last;
        endcase
    end

endmodule

// File: rtl/i2c_tim_fsm.sv
// Phase sequencer: idle, parked, low, wait-for-high, high.
module i2c_tim_fsm
    import i2c_tim_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  op_e           cmd_op,
    input  logic          scl_in,
    input  logic [CW-1:0] new_low_end,
    input  logic [CW-1:0] new_chg_at,
    input  logic [CW-1:0] new_edge_at,
    input  logic [CW-1:0] new_hi_end,
    output phase_e        ph_o,
    output logic [CW-1:0] cnt_o,
    output op_e           op_o,
    output logic [CW-1:0] chg_at_o,
    output logic [CW-1:0] edge_at_o,
    output logic [CW-1:0] hi_end_o
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        op_e           op;
        logic [CW-1:0] low_end;
        logic [CW-1:0] chg_at;
        logic [CW-1:0] edge_at;
        logic [CW-1:0] hi_end;
    } tim_state_t;

    tim_state_t st_d, st_q;
    logic       take_cmd;

    always_comb begin
        st_d     = st_q;
        take_cmd = 1'b0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (cmd_valid && (cmd_op == OP_START)) begin
                    take_cmd = 1'b1;
                    st_d.ph  = PH_WAIT;
                end
            end
            PH_PARK: begin
                if (cmd_valid && (cmd_op != OP_START)) begin
                    take_cmd = 1'b1;
                    st_d.ph  = PH_LOW;
                end
            end
            PH_LOW: begin
                if (st_q.cnt == st_q.low_end) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_WAIT: begin
                if (scl_in) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end
            end
            PH_HIGH: begin
                if (st_q.cnt == st_q.hi_end) begin
                    st_d.ph  = (st_q.op == OP_STOP) ? PH_IDLE : PH_PARK;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase

        if (take_cmd) begin
            st_d.cnt     = '0;
            st_d.op      = cmd_op;
            st_d.low_end = new_low_end;
            st_d.chg_at  = new_chg_at;
            st_d.edge_at = new_edge_at;
            st_d.hi_end  = new_hi_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph      <= PH_IDLE;
            st_q.cnt     <= '0;
            st_q.op      <= OP_BIT;
            st_q.low_end <= '0;
            st_q.chg_at  <= '0;
            st_q.edge_at <= '0;
            st_q.hi_end  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_o      = st_q.ph;
    assign cnt_o     = st_q.cnt;
    assign op_o      = st_q.op;
    assign chg_at_o  = st_q.chg_at;
    assign edge_at_o = st_q.edge_at;
    assign hi_end_o  = st_q.hi_end;

endmodule

// File: rtl/i2c_tim_strobe.sv
// Decodes phase and count into line drive and sequencer strobes.
module i2c_tim_strobe
    import i2c_tim_pkg::*;
#(
    parameter int CW = 16
) (
    input  phase_e        ph,
    input  logic [CW-1:0] cnt,
    input  op_e           op,
    input  logic [CW-1:0] chg_at,
    input  logic [CW-1:0] edge_at,
    input  logic [CW-1:0] hi_end,
    output logic          ready,
    output logic          drive_low,
    output logic          change,
    output logic          sample,
    output logic          start_e,
    output logic          stop_e,
    output logic          done
);
    logic in_high;
    logic at_edge;
    logic is_start;

    always_comb begin
        in_high   = (ph == PH_HIGH);
        at_edge   = in_high && (cnt == edge_at);
        is_start  = (op == OP_START) || (op == OP_RESTART);

        ready     = (ph == PH_IDLE) || (ph == PH_PARK);
        drive_low = (ph == PH_PARK) || (ph == PH_LOW);
        change    = (ph == PH_LOW) && (cnt == chg_at);
        sample    = in_high && (op == OP_BIT) && (cnt == '0);
        start_e   = at_edge && is_start;
        stop_e    = at_edge && (op == OP_STOP);
        done      = in_high && (cnt == hi_end);
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_tim_pkg::*;
#(
    parameter int CW     = 16,
    parameter int SYS_HZ = 100_000_000,
    parameter int BUS_HZ = 100_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_auto,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    output logic          cmd_ready,
    input  logic          scl_in,
    output logic          scl_drive_low,
    output logic          sda_change,
    output logic          sda_sample,
    output logic          start_edge,
    output logic          stop_edge,
    output logic          cmd_done
);
    localparam int BUS_EFF = (BUS_HZ <= 0) ? 100_000 :
                             ((BUS_HZ > 400_000) ? 400_000 : BUS_HZ);
    localparam int DEF_RAW = SYS_HZ / BUS_EFF;
    localparam int CNT_MAX = (1 << CW) - 1;
    localparam int DEF_CLP = (DEF_RAW < 1) ? 1 :
                             ((DEF_RAW > CNT_MAX) ? CNT_MAX : DEF_RAW);
    localparam logic [CW-1:0] DEF_PERIOD = CW'(DEF_CLP);

    op_e           op_in;
    logic [CW-1:0] n_low_end, n_chg_at, n_edge_at, n_hi_end;
    phase_e        ph;
    logic [CW-1:0] cnt;
    op_e           op_cur;
    logic [CW-1:0] chg_at, edge_at, hi_end;

    assign op_in = op_e'(cmd_op);

    i2c_tim_cfg #(.CW(CW), .DEF_PERIOD(DEF_PERIOD)) u_cfg (
        .cfg_auto   (cfg_auto),
        .cfg_period (cfg_period),
        .cfg_low    (cfg_low),
        .cfg_setup  (cfg_setup),
        .cfg_dsetup (cfg_dsetup),
        .op         (op_in),
        .low_end    (n_low_end),
        .chg_at     (n_chg_at),
        .edge_at    (n_edge_at),
        .hi_end     (n_hi_end)
    );

    i2c_tim_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (op_in),
        .scl_in      (scl_in),
        .new_low_end (n_low_end),
        .new_chg_at  (n_chg_at),
        .new_edge_at (n_edge_at),
        .new_hi_end  (n_hi_end),
        .ph_o        (ph),
        .cnt_o       (cnt),
        .op_o        (op_cur),
        .chg_at_o    (chg_at),
        .edge_at_o   (edge_at),
        .hi_end_o    (hi_end)
    );

    i2c_tim_strobe #(.CW(CW)) u_strobe (
        .ph        (ph),
        .cnt       (cnt),
        .op        (op_cur),
        .chg_at    (chg_at),
        .edge_at   (edge_at),
        .hi_end    (hi_end),
        .ready     (cmd_ready),
        .drive_low (scl_drive_low),
        .change    (sda_change),
        .sample    (sda_sample),
        .start_e   (start_edge),
        .stop_e    (stop_edge),
        .done      (cmd_done)
    );

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic cmd_ready,
    input logic scl_drive_low,
    input logic sda_change,
    input logic sda_sample,
    input logic start_edge,
    input logic stop_edge,
    input logic cmd_done
);
    a_r4_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> (scl_drive_low && !cmd_ready));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_change, sda_sample, start_edge, stop_edge}));

    a_r5_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |->
            !(sda_sample || start_edge || stop_edge || cmd_done));

    a_r6_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_ready);

    a_r7_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |-> (!scl_drive_low && scl_in));

    a_r8_stop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        stop_edge |-> cmd_done);

    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_edge |=> (!scl_drive_low && cmd_ready));

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(sda_change || sda_sample || start_edge || stop_edge || cmd_done));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .cmd_ready     (cmd_ready),
    .scl_drive_low (scl_drive_low),
    .sda_change    (sda_change),
    .sda_sample    (sda_sample),
    .start_edge    (start_edge),
    .stop_edge     (stop_edge),
    .cmd_done      (cmd_done)
);

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;
    localparam int CW      = 16;
    localparam int SYS     = 4_000_000;
    localparam int BUS     = 400_000;
    localparam int DEF_PER = SYS / BUS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_auto = 1'b0;
    logic [CW-1:0] cfg_period = '0;
    logic [CW-1:0] cfg_low = '0;
    logic [CW-1:0] cfg_setup = '0;
    logic [CW-1:0] cfg_dsetup = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          stretch = 1'b0;
    logic          cmd_ready, scl_in, scl_drive_low, sda_change, sda_sample;
    logic          start_edge, stop_edge, cmd_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    assign scl_in = !scl_drive_low && !stretch;

    i2c_scl_timer #(.CW(CW), .SYS_HZ(SYS), .BUS_HZ(BUS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_period(cfg_period),
        .cfg_low(cfg_low), .cfg_setup(cfg_setup), .cfg_dsetup(cfg_dsetup),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .scl_in(scl_in), .scl_drive_low(scl_drive_low), .sda_change(sda_change),
        .sda_sample(sda_sample), .start_edge(start_edge), .stop_edge(stop_edge),
        .cmd_done(cmd_done)
    );

    // Model: queue of expected output vectors, bit 7 marks a wait-for-high slot.
    // Vector bits: 0 drive_low, 1 change, 2 sample, 3 start, 4 stop, 5 done.
    logic [7:0] q[$];
    bit         parked = 1'b0;

    task automatic build(input int op);
        int p, lr, su, ds, le, de, hi, hend;
        p  = (cfg_period == 0) ? DEF_PER : int'(cfg_period);
        lr = cfg_auto ? p / 2  : int'(cfg_low);
        su = cfg_auto ? p / 2  : int'(cfg_setup);
        ds = cfg_auto ? p / 16 : int'(cfg_dsetup);
        le = (lr == 0) ? 1 : lr;
        de = (ds == 0) ? 1 : ((ds > le) ? le : ds);
        hi = (p > le) ? p - le : 1;
        if (op == 0)      hend = hi - 1;
        else if (op == 3) hend = su;
        else              hend = (su > hi - 1) ? su : hi - 1;
        if (op != 1)
            for (int i = 0; i < le; i++)
                q.push_back({6'b0, (i == le - de), 1'b1});
        q.push_back(8'h80);
        for (int i = 0; i <= hend; i++) begin
            logic [7:0] v;
            v = 8'h00;
            v[2] = (op == 0) && (i == 0);
            v[3] = (op == 1 || op == 2) && (i == su);
            v[4] = (op == 3) && (i == su);
            v[5] = (i == hend);
            q.push_back(v);
        end
        parked = (op != 3);
    endtask

    task automatic advance();
        bit was_empty;
        bit legal;
        was_empty = (q.size() == 0);
        if (!was_empty) begin
            if (q[0][7]) begin
                if (!stretch) void'(q.pop_front());
            end else begin
                void'(q.pop_front());
            end
        end
        legal = parked ? (cmd_op != 2'd1) : (cmd_op == 2'd1);
        if (was_empty && cmd_valid && rst_n && legal) build(int'(cmd_op));
    endtask

    task automatic step(input string tag);
        logic [5:0] exp_v, act_v;
        logic       exp_r;
        @(negedge clk);
        #1;
        advance();
        if (q.size() == 0) begin
            exp_v = {5'b0, parked};
            exp_r = 1'b1;
        end else if (q[0][7]) begin
            exp_v = 6'b0;
            exp_r = 1'b0;
        end else begin
            exp_v = q[0][5:0];
            exp_r = 1'b0;
        end
        act_v = {cmd_done, stop_edge, start_edge, sda_sample, sda_change, scl_drive_low};
        checks++;
        if (act_v !== exp_v || cmd_ready !== exp_r) begin
            failures++;
            $display("FAIL [%s] t=%0t outputs act=%b exp=%b ready act=%b exp=%b",
                     tag, $time, act_v, exp_v, cmd_ready, exp_r);
        end
    endtask

    task automatic finish_op(input string tag);
        int guard;
        guard = 0;
        while (q.size() != 0 && guard < 3000) begin
            step(tag);
            guard++;
        end
        step(tag);
    endtask

    task automatic do_cmd(input int op, input string tag);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        step(tag);
        cmd_valid = 1'b0;
        finish_op(tag);
    endtask

    task automatic set_cfg(input int p, input int l, input int s, input int d);
        cfg_period = CW'(p);
        cfg_low    = CW'(l);
        cfg_setup  = CW'(s);
        cfg_dsetup = CW'(d);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            failures++;
            $display("FAIL [watchdog] run did not finish act=%0d exp<=60000", cycles);
            report();
        end
    end

    initial begin
        set_cfg(12, 6, 3, 2);
        // R1: reset state
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");

        // R10: non-START commands in idle are dropped
        cmd_valid = 1'b1; cmd_op = 2'd0;
        step("R10"); step("R10"); step("R10");
        cmd_op = 2'd3;
        step("R10"); step("R10");
        cmd_valid = 1'b0;
        step("R10");

        // R7: START from idle
        do_cmd(1, "R7");
        // R3 / R4 / R6: bits
        do_cmd(0, "R6");
        do_cmd(0, "R4");

        // R10: START while parked is dropped
        cmd_valid = 1'b1; cmd_op = 2'd1;
        step("R10"); step("R10"); step("R10");
        cmd_valid = 1'b0;
        step("R10");

        // R5: stretched clock during a bit
        stretch = 1'b1;
        cmd_valid = 1'b1; cmd_op = 2'd0;
        step("R5");
        cmd_valid = 1'b0;
        for (int i = 0; i < 12; i++) step("R5");
        stretch = 1'b0;
        finish_op("R5");

        // R7: repeated START
        do_cmd(2, "R7");

        // R9: command held valid across a busy bit
        cmd_valid = 1'b1; cmd_op = 2'd0;
        step("R9");
        begin
            int guard;
            guard = 0;
            while (q.size() > 1 && guard < 3000) begin
                step("R9");
                guard++;
            end
        end
        cmd_valid = 1'b0;
        finish_op("R9");

        // R11: counts changed mid-command
        cmd_valid = 1'b1; cmd_op = 2'd0;
        step("R11");
        cmd_valid = 1'b0;
        step("R11"); step("R11");
        set_cfg(5, 2, 1, 1);
        finish_op("R11");
        set_cfg(12, 6, 3, 2);

        // R8: STOP
        do_cmd(3, "R8");

        // R2: automatic counts with built-in period, then explicit period
        cfg_auto = 1'b1;
        set_cfg(0, 0, 0, 0);
        do_cmd(1, "R2");
        do_cmd(0, "R2");
        cfg_period = CW'(20);
        do_cmd(0, "R2");
        do_cmd(3, "R2");
        cfg_auto = 1'b0;

        // R3: long low phase
        set_cfg(14, 9, 2, 3);
        do_cmd(1, "R3");
        do_cmd(0, "R3");

        // R7 / R4: edge setup beyond high time, data setup beyond low time
        set_cfg(8, 6, 4, 9);
        do_cmd(0, "R4");
        do_cmd(2, "R7");
        // R4 / R6: zero low and zero data setup clamp to one
        set_cfg(3, 0, 0, 0);
        do_cmd(0, "R6");
        set_cfg(8, 6, 4, 9);
        do_cmd(3, "R8");

        step("R1");
        report();
    end

endmodule